// File: doc/BRIEF.md
# DMA Channel Drain and Disable Controller

This block is the datapath and control of one DMA channel. Beats read from the source enter a 16-byte channel buffer. The buffer packs or splits those bytes into destination-width words and hands them to the destination. The source and destination are plain valid/ready ports. Software steers the channel with single-cycle pulses: start, stop request, suspend and resume. A level global enable sits above these. Software reads back three status bits: channel on, suspended, and "cannot form a destination word".

There are two ways to stop the channel. The graceful stop is a sequence: suspend, poll the status until it shows that no full destination word remains, then request the stop. The abrupt stop is a stop request on its own, which throws away whatever bytes remain. In both cases the stop is deferred. The channel keeps running while a destination word is being accepted, and it turns off on the first edge with no destination handshake. It never waits for an acknowledge that may not come.

Top module: `dmadrn_chan`

## Requirements
- R1: After synchronous reset the channel is off and not suspended, and the buffer holds zero bytes. The configuration is 1-byte source, 1-byte destination, and no flow controller.
- R2: Width codes are 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Bytes leave in the order they arrived. Packing is little-endian: the oldest byte sits in lane 0 (bits 7:0) of `dst_data`. Lanes at or above the destination width read as zero.
- R3: `src_ready` is high only when all of these hold: the channel is on, it is not suspended, no stop is pending, flow control allows it, and the 16-byte buffer has room for a full source beat.
- R4: `dst_valid` is high only when the channel is on, the buffer holds at least one destination word, and flow control allows it.
- R5: `stat_empty` is high exactly when the buffer holds fewer bytes than one destination word, even when some bytes remain.
- R6: A suspend pulse while the channel is on sets `stat_susp`. This stops source acceptance. Destination words keep leaving while enough bytes remain.
- R7: A resume pulse clears `stat_susp`, and it wins over a suspend pulse in the same cycle. Leftover partial bytes combine with later source bytes into normal words.
- R8: A stop pulse is a request only. `stat_en` stays 1 on every edge where a destination word is accepted. The channel turns off on the first edge where the request is pending and no destination handshake occurs.
- R9: A low `glb_en` acts as a stop request on an enabled channel and follows the R8 timing. A start pulse while `glb_en` is low is ignored.
- R10: When the channel turns off, the buffer count returns to zero and the suspend and last-transfer flags clear. Discarded bytes never appear at the destination after a later start.
- R11: `cfg_we` loads the source width, destination width and flow selection only while the channel is off. While it is on, the write has no effect.
- R12: Flow code 2 marks the destination as flow controller. In that mode `src_ready` stays 0 until `dst_last` has been seen high at an edge while the channel is on. Flow code 1 marks the source as flow controller. In that mode `dst_valid` stays 0 until `src_last` has been seen the same way.
- R13: A stop request while the destination holds `dst_ready` low turns the channel off at the next edge, without waiting for an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global enable level; low requests a stop |
| ch_en | input | 1 | Start pulse |
| ch_dis | input | 1 | Stop request pulse |
| ch_susp | input | 1 | Suspend pulse |
| ch_res | input | 1 | Resume pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src_w | input | 2 | Source width code |
| cfg_dst_w | input | 2 | Destination width code |
| cfg_flow | input | 2 | Flow controller select (0 none, 1 source, 2 destination) |
| src_valid | input | 1 | Source beat valid |
| src_data | input | 32 | Source beat, byte lanes from bit 0 upward |
| src_last | input | 1 | Source last-transfer flag |
| src_ready | output | 1 | Source beat accepted when high with valid |
| dst_valid | output | 1 | Destination word valid |
| dst_data | output | 32 | Destination word |
| dst_ready | input | 1 | Destination accepts the word |
| dst_last | input | 1 | Destination last-transfer flag |
| stat_en | output | 1 | Channel is on |
| stat_susp | output | 1 | Channel is suspended |
| stat_empty | output | 1 | Fewer bytes than one destination word remain |

## Verification
The bench targets five corner cases.

- Partial-word empty: two bytes are left under a 4-byte destination while suspended. A design that flagged empty only at zero bytes would report not-empty.
- Deferred stop: a stop is requested during a run of accepted destination words. A design that stopped at once would drop words or turn `stat_en` off early.
- Stop with no acknowledge: a stop is requested while the destination stalls. A design that waited for an acknowledge would hang with `stat_en` stuck at 1.
- Residual after restart: three bytes are left behind by an abrupt stop. A design that kept them would mix them into the first word after the next start.
- Ignored writes and flow gating: configuration writes arrive while the channel is on, and flow control holds transfers until the other side's last-transfer flag. Getting either wrong changes the width or releases transfers too early, which the per-cycle model comparison exposes.

// File: rtl/dmadrn_pkg.sv
package dmadrn_pkg;

  typedef enum logic [1:0] {
    FLOW_SELF = 2'd0,
    FLOW_SRC  = 2'd1,
    FLOW_DST  = 2'd2,
    FLOW_RSVD = 2'd3
  } flow_e;

  typedef struct packed {
    logic [1:0] src_w;
    logic [1:0] dst_w;
    flow_e      flow;
  } chan_cfg_t;

  // width code to byte count: 0 -> 1, 1 -> 2, 2/3 -> 4
  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dmadrn_bytefifo.sv
// Byte-granular circular buffer: pushes and pops a variable number of
// byte lanes per cycle. DEPTH must be a power of two.
module dmadrn_bytefifo #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int FW = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 push,
  input  logic [2:0]           push_n,
  input  logic [8*LANES-1:0]   push_data,
  input  logic                 pop,
  input  logic [2:0]           pop_n,
  output logic [FW-1:0]        fill,
  output logic [8*LANES-1:0]   peek
);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (push && (k < int'(push_n)))
        mem[wp + PW'(k)] <= push_data[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= wp + PW'(push_n);
      if (pop)  rp <= rp + PW'(pop_n);
      fill <= fill + (push ? FW'(push_n) : FW'(0)) - (pop ? FW'(pop_n) : FW'(0));
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++)
      peek[8*k +: 8] = (k < int'(pop_n)) ? mem[rp + PW'(k)] : 8'h00;
  end

endmodule

// File: rtl/dmadrn_ctrl.sv
// Channel state: on/off, suspend, pending stop, flow-control flags, config.
module dmadrn_ctrl
  import dmadrn_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      glb_en,
  input  logic      ch_en,
  input  logic      ch_dis,
  input  logic      ch_susp,
  input  logic      ch_res,
  input  logic      cfg_we,
  input  chan_cfg_t cfg_in,
  input  logic      src_last,
  input  logic      dst_last,
  input  logic      dst_fire,
  output logic      enabled,
  output logic      susp,
  output logic      stop_now,
  output logic      flush,
  output chan_cfg_t cfg,
  output logic      src_gate,
  output logic      dst_gate
);

  logic dreq, slast_seen, dlast_seen;

  assign stop_now = enabled & (dreq | ch_dis | ~glb_en);
  assign flush    = stop_now & ~dst_fire;
  assign src_gate = (cfg.flow != FLOW_DST) | dlast_seen;
  assign dst_gate = (cfg.flow != FLOW_SRC) | slast_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      enabled    <= 1'b0;
      susp       <= 1'b0;
      dreq       <= 1'b0;
      slast_seen <= 1'b0;
      dlast_seen <= 1'b0;
      cfg        <= '0;
    end else if (!enabled) begin
      if (cfg_we)           cfg     <= cfg_in;
      if (ch_en && glb_en)  enabled <= 1'b1;
    end else if (flush) begin
      enabled    <= 1'b0;
      susp       <= 1'b0;
      dreq       <= 1'b0;
      slast_seen <= 1'b0;
      dlast_seen <= 1'b0;
    end else begin
      if (stop_now) dreq <= 1'b1;
      if (ch_res)       susp <= 1'b0;
      else if (ch_susp) susp <= 1'b1;
      if (src_last) slast_seen <= 1'b1;
      if (dst_last) dlast_seen <= 1'b1;
    end
  end

endmodule

// File: rtl/dmadrn_chan.sv
module dmadrn_chan
  import dmadrn_pkg::*;
#(
  parameter int FIFO_BYTES = 16,
  parameter int LANES      = 4,
  localparam int DATA_W = 8 * LANES,
  localparam int FILL_W = $clog2(FIFO_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              glb_en,
  input  logic              ch_en,
  input  logic              ch_dis,
  input  logic              ch_susp,
  input  logic              ch_res,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_src_w,
  input  logic [1:0]        cfg_dst_w,
  input  logic [1:0]        cfg_flow,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_last,
  output logic              src_ready,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data,
  input  logic              dst_ready,
  input  logic              dst_last,
  output logic              stat_en,
  output logic              stat_susp,
  output logic              stat_empty
);

  chan_cfg_t         cfg_in, cfg;
  logic [5:0]        cfg_word;
  logic              enabled, susp, stop_now, flush, src_gate, dst_gate;
  logic              src_fire, dst_fire;
  logic [2:0]        sb, db;
  logic [FILL_W-1:0] fill;
  logic [FILL_W:0]   room;

  assign cfg_in   = '{src_w: cfg_src_w, dst_w: cfg_dst_w, flow: flow_e'(cfg_flow)};
  assign cfg_word = cfg;

  dmadrn_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .glb_en   (glb_en),
    .ch_en    (ch_en),
    .ch_dis   (ch_dis),
    .ch_susp  (ch_susp),
    .ch_res   (ch_res),
    .cfg_we   (cfg_we),
    .cfg_in   (cfg_in),
    .src_last (src_last),
    .dst_last (dst_last),
    .dst_fire (dst_fire),
    .enabled  (enabled),
    .susp     (susp),
    .stop_now (stop_now),
    .flush    (flush),
    .cfg      (cfg),
    .src_gate (src_gate),
    .dst_gate (dst_gate)
  );

  assign sb   = width_bytes(cfg.src_w);
  assign db   = width_bytes(cfg.dst_w);
  assign room = (FILL_W+1)'(FIFO_BYTES) - {1'b0, fill};

  assign src_ready = enabled & ~susp & ~stop_now & src_gate & (room >= (FILL_W+1)'(sb));
  assign dst_valid = enabled & dst_gate & (fill >= FILL_W'(db));
  assign src_fire  = src_valid & src_ready;
  assign dst_fire  = dst_valid & dst_ready;

  dmadrn_bytefifo #(
    .DEPTH (FIFO_BYTES),
    .LANES (LANES)
  ) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .push      (src_fire),
    .push_n    (sb),
    .push_data (src_data),
    .pop       (dst_fire),
    .pop_n     (db),
    .fill      (fill),
    .peek      (dst_data)
  );

  assign stat_en    = enabled;
  assign stat_susp  = susp;
  assign stat_empty = fill < FILL_W'(db);

endmodule

// File: rtl/dmadrn_chan_chk.sv
module dmadrn_chan_chk #(
  parameter int FW    = 5,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          glb_en,
  input logic          ch_dis,
  input logic          ch_res,
  input logic          src_ready,
  input logic          dst_valid,
  input logic          dst_ready,
  input logic          stat_en,
  input logic          stat_susp,
  input logic          stat_empty,
  input logic [FW-1:0] fill,
  input logic [5:0]    cfg_bits
);

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(fill) <= DEPTH); // R3

  AST_SUSP_BLOCKS_SRC: assert property (@(posedge clk) disable iff (rst)
    stat_susp |-> !src_ready); // R6

  AST_EMPTY_NO_DST: assert property (@(posedge clk) disable iff (rst)
    stat_empty |-> !dst_valid); // R5

  AST_STOP_DEFERRED: assert property (@(posedge clk) disable iff (rst)
    (stat_en && ch_dis && dst_valid && dst_ready) |=> stat_en); // R8

  AST_NO_HANG: assert property (@(posedge clk) disable iff (rst)
    (stat_en && ch_dis && !(dst_valid && dst_ready)) |=> !stat_en); // R13

  AST_GLB_STOP: assert property (@(posedge clk) disable iff (rst)
    (stat_en && !glb_en) |-> !src_ready); // R9

  AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (stat_en && ch_res) |=> !stat_susp); // R7

  AST_OFF_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_en) |-> (stat_empty && !stat_susp)); // R10

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    stat_en |=> $stable(cfg_bits)); // R11

endmodule

bind dmadrn_chan dmadrn_chan_chk #(
  .FW    (FILL_W),
  .DEPTH (FIFO_BYTES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .glb_en     (glb_en),
  .ch_dis     (ch_dis),
  .ch_res     (ch_res),
  .src_ready  (src_ready),
  .dst_valid  (dst_valid),
  .dst_ready  (dst_ready),
  .stat_en    (stat_en),
  .stat_susp  (stat_susp),
  .stat_empty (stat_empty),
  .fill       (fill),
  .cfg_bits   (cfg_word)
);

// File: tb/dmadrn_chan_test.sv
`timescale 1ns/1ps
module dmadrn_chan_test;

  localparam int FB = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        glb_en, ch_en, ch_dis, ch_susp, ch_res, cfg_we;
  logic [1:0]  cfg_src_w, cfg_dst_w, cfg_flow;
  logic        src_valid, src_last, src_ready;
  logic [31:0] src_data;
  logic        dst_valid, dst_ready, dst_last;
  logic [31:0] dst_data;
  logic        stat_en, stat_susp, stat_empty;

  logic [7:0]  seq = 8'd0;
  assign src_data = {seq + 8'd3, seq + 8'd2, seq + 8'd1, seq};

  always #4 clk = ~clk;

  dmadrn_chan uut (
    .clk(clk), .rst(rst), .glb_en(glb_en), .ch_en(ch_en), .ch_dis(ch_dis),
    .ch_susp(ch_susp), .ch_res(ch_res), .cfg_we(cfg_we), .cfg_src_w(cfg_src_w),
    .cfg_dst_w(cfg_dst_w), .cfg_flow(cfg_flow), .src_valid(src_valid),
    .src_data(src_data), .src_last(src_last), .src_ready(src_ready),
    .dst_valid(dst_valid), .dst_data(dst_data), .dst_ready(dst_ready),
    .dst_last(dst_last), .stat_en(stat_en), .stat_susp(stat_susp),
    .stat_empty(stat_empty)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural reference state
  bit         m_en, m_susp, m_dreq, m_slast, m_dlast;
  logic [1:0] m_sw, m_dw, m_flow;
  logic [7:0] q[$];
  bit         e_stop, e_src_ready, e_dst_valid, e_empty;
  logic [31:0] e_data;

  function automatic int wb(logic [1:0] c);
    return (c == 2'd0) ? 1 : ((c == 2'd1) ? 2 : 4);
  endfunction

  task automatic eval();
    int sb, db;
    sb = wb(m_sw);
    db = wb(m_dw);
    e_stop      = m_en && (m_dreq || ch_dis || !glb_en);
    e_src_ready = m_en && !m_susp && !e_stop && ((FB - q.size()) >= sb) &&
                  (m_flow != 2'd2 || m_dlast);
    e_dst_valid = m_en && (q.size() >= db) && (m_flow != 2'd1 || m_slast);
    e_empty     = q.size() < db;
    e_data      = 32'h0;
    if (q.size() >= db)
      for (int k = 0; k < db; k++) e_data[8*k +: 8] = q[k];
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_susp = 0; m_dreq = 0; m_slast = 0; m_dlast = 0;
      m_sw = 2'd0; m_dw = 2'd0; m_flow = 2'd0;
      q.delete();
    end else begin
      int sb, db;
      bit sf, df;
      eval();
      sb = wb(m_sw);
      db = wb(m_dw);
      sf = src_valid && e_src_ready;
      df = e_dst_valid && dst_ready;
      if (!m_en) begin
        if (cfg_we) begin m_sw = cfg_src_w; m_dw = cfg_dst_w; m_flow = cfg_flow; end
        if (ch_en && glb_en) m_en = 1;
      end else if (e_stop && !df) begin
        m_en = 0; m_susp = 0; m_dreq = 0; m_slast = 0; m_dlast = 0;
        q.delete();
      end else begin
        if (df) for (int k = 0; k < db; k++) void'(q.pop_front());
        if (sf) for (int k = 0; k < sb; k++) q.push_back(src_data[8*k +: 8]);
        if (e_stop) m_dreq = 1;
        if (ch_res) m_susp = 0;
        else if (ch_susp) m_susp = 1;
        if (src_last) m_slast = 1;
        if (dst_last) m_dlast = 1;
      end
      if (sf) seq <= seq + 8'(sb);
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (!rst && !done) begin
      eval();
      check(32'(src_ready),  32'(e_src_ready), "R3 src_ready");
      check(32'(dst_valid),  32'(e_dst_valid), "R4 dst_valid");
      if (e_dst_valid) check(dst_data, e_data, "R2 dst_data");
      check(32'(stat_empty), 32'(e_empty),     "R5 stat_empty");
      check(32'(stat_en),    32'(m_en),        "R8 stat_en");
      check(32'(stat_susp),  32'(m_susp),      "R6 stat_susp");
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic pulse(input int which);
    case (which)
      0: ch_en = 1; 1: ch_dis = 1; 2: ch_susp = 1;
      3: ch_res = 1; 4: src_last = 1; default: dst_last = 1;
    endcase
    @(negedge clk);
    ch_en = 0; ch_dis = 0; ch_susp = 0; ch_res = 0; src_last = 0; dst_last = 0;
  endtask

  task automatic set_cfg(input logic [1:0] s, input logic [1:0] d, input logic [1:0] f);
    cfg_we = 1; cfg_src_w = s; cfg_dst_w = d; cfg_flow = f;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic src_beats(input int n);
    int left = n;
    int guard = 0;
    src_valid = 1;
    while (left > 0 && guard < 200) begin
      #2;
      if (src_ready) left--;
      guard++;
      @(negedge clk);
    end
    src_valid = 0;
  endtask

  task automatic wait_valid();
    int g = 0;
    #2;
    while (!dst_valid && g < 50) begin
      @(negedge clk);
      #2;
      g++;
    end
  endtask

  initial begin
    rst = 1; glb_en = 1; ch_en = 0; ch_dis = 0; ch_susp = 0; ch_res = 0;
    cfg_we = 0; cfg_src_w = 0; cfg_dst_w = 0; cfg_flow = 0;
    src_valid = 0; src_last = 0; dst_ready = 0; dst_last = 0;
    idle(4);
    rst = 0;
    #2;
    check(32'(stat_en), 0, "R1 reset stat_en");
    check(32'(stat_susp), 0, "R1 reset stat_susp");
    check(32'(stat_empty), 1, "R1 reset stat_empty");
    check(32'(dst_valid), 0, "R1 reset dst_valid");
    @(negedge clk);

    // graceful stop path: 1-byte source into 4-byte destination
    set_cfg(2'd0, 2'd2, 2'd0);
    pulse(0);
    dst_ready = 1;
    src_beats(6);                 // bytes 0..5, one word leaves, 2 remain
    set_cfg(2'd0, 2'd0, 2'd0);    // R11: ignored while on
    #2;
    check(32'(stat_empty), 1, "R11 cfg write ignored, still 4-byte words");
    check(32'(dst_valid), 0, "R5 two bytes cannot form a word");
    @(negedge clk);
    pulse(2);
    src_valid = 1;
    #2;
    check(32'(src_ready), 0, "R6 suspend stops source");
    check(32'(stat_susp), 1, "R6 stat_susp set");
    check(32'(stat_empty), 1, "R5 empty with residual bytes");
    @(negedge clk);
    src_valid = 0;
    pulse(3);
    #2;
    check(32'(stat_susp), 0, "R7 resume clears suspend");
    @(negedge clk);
    src_beats(2);                 // bytes 6,7
    wait_valid();
    check(dst_data, 32'h07060504, "R7 leftover bytes joined with new ones");
    @(negedge clk);
    idle(2);

    // abrupt stop discards residual
    src_beats(3);                 // bytes 8,9,10
    pulse(1);
    #2;
    check(32'(stat_en), 0, "R8 off at first edge without handshake");
    @(negedge clk);
    pulse(0);
    src_beats(4);                 // bytes 11..14
    wait_valid();
    check(dst_data, 32'h0E0D0C0B, "R10 residual not delivered after restart");
    @(negedge clk);
    idle(2);

    // deferred stop while words drain
    dst_ready = 0;
    src_beats(16);
    src_valid = 1;
    #2;
    check(32'(src_ready), 0, "R3 full buffer refuses source");
    @(negedge clk);
    src_valid = 0;
    dst_ready = 1;
    pulse(1);
    #2;
    check(32'(stat_en), 1, "R8 stop deferred during handshake");
    @(negedge clk);
    idle(4);
    #2;
    check(32'(stat_en), 0, "R8 stop completes after drain");
    @(negedge clk);

    // stop with destination stalled: no hang
    pulse(0);
    dst_ready = 0;
    src_beats(8);
    pulse(1);
    #2;
    check(32'(stat_en), 0, "R13 stop without acknowledge");
    @(negedge clk);
    pulse(0);
    #2;
    check(32'(stat_empty), 1, "R10 count cleared on stop");
    check(32'(dst_valid), 0, "R10 nothing left after restart");
    @(negedge clk);

    // global enable
    glb_en = 0;
    @(negedge clk);
    #2;
    check(32'(stat_en), 0, "R9 global low stops channel");
    @(negedge clk);
    pulse(0);
    #2;
    check(32'(stat_en), 0, "R9 start ignored while global low");
    @(negedge clk);
    glb_en = 1;
    pulse(0);
    dst_ready = 0;
    src_beats(8);
    dst_ready = 1;
    glb_en = 0;
    @(negedge clk);
    #2;
    check(32'(stat_en), 1, "R9 global stop deferred");
    @(negedge clk);
    @(negedge clk);
    #2;
    check(32'(stat_en), 0, "R9 global stop completes");
    @(negedge clk);
    glb_en = 1;

    // flow control: destination controls
    set_cfg(2'd1, 2'd1, 2'd2);
    pulse(0);
    src_valid = 1;
    idle(2);
    #2;
    check(32'(src_ready), 0, "R12 source held until destination last");
    @(negedge clk);
    pulse(5);
    #2;
    check(32'(src_ready), 1, "R12 source released by destination last");
    @(negedge clk);
    src_valid = 0;
    idle(3);
    pulse(1);
    idle(2);

    // flow control: source controls
    set_cfg(2'd1, 2'd1, 2'd1);
    pulse(0);
    src_beats(2);
    #2;
    check(32'(dst_valid), 0, "R12 destination held until source last");
    @(negedge clk);
    pulse(4);
    #2;
    check(32'(dst_valid), 1, "R12 destination released by source last");
    @(negedge clk);
    idle(4);
    pulse(1);
    idle(2);

    // wide source into narrow destination, then code 3
    set_cfg(2'd2, 2'd0, 2'd0);
    pulse(0);
    src_beats(2);
    idle(10);
    pulse(1);
    idle(2);
    set_cfg(2'd1, 2'd3, 2'd0);
    pulse(0);
    src_beats(6);
    idle(6);
    pulse(1);
    idle(2);

    // random traffic, compared every cycle
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 100);
      src_valid = ($urandom % 4) != 0;
      dst_ready = ($urandom % 3) != 0;
      ch_en   = (r < 6);
      ch_dis  = (r >= 6 && r < 8);
      ch_susp = (r >= 8 && r < 11);
      ch_res  = (r >= 11 && r < 15);
      src_last = ($urandom % 50) == 0;
      dst_last = ($urandom % 50) == 0;
      cfg_we   = ($urandom % 20) == 0;
      cfg_src_w = 2'($urandom);
      cfg_dst_w = 2'($urandom);
      cfg_flow  = 2'($urandom);
      glb_en    = ($urandom % 200) != 0;
      @(negedge clk);
    end
    ch_en = 0; ch_dis = 0; ch_susp = 0; ch_res = 0; cfg_we = 0;
    src_last = 0; dst_last = 0; src_valid = 0; glb_en = 1;
    idle(4);
    done = 1;
    summary();
    $finish;
  end

endmodule